// File: doc/BRIEF.md
# SDRAM Single-Write Command Sequencer

This block produces the SDRAM pin activity for one isolated write access. A request carries a bank, a row, a column, one data word and per-byte enables. The sequencer first spends one lead cycle in which it pulses the DMA acknowledge. It then opens the row with ACTIVE. In the next cycle it issues WRITE with auto-precharge and drives the data word on the same cycle. The device is programmed for a burst of 4 or 8, so the rest of the burst is filled with masked dummy beats. After that the sequencer holds the bus idle for a programmable write-recovery time and then for a programmable precharge wait. No other command can go out until both waits have finished.

Requests use a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The bank, row, column, data, byte enables and the three configuration fields are all captured on that edge. While `busy` is high, `req_ready` stays low, and a requester that keeps `req_valid` high simply waits. Nothing on the request or configuration pins affects the access once it has been accepted.

Top module: `sdram_wr_seq`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `busy`=0, `dma_ack`=0, `sd_dq_oe`=0, all `sd_dqm` bits 1, and the command pins show NOP.
- R2: A request is accepted only on an edge with `req_valid`=1 and `req_ready`=1. While busy, `req_ready` is 0, and a held `req_valid` starts no access until the block is idle again.
- R3: In the second cycle after acceptance, ACTIVE is driven (cs_n,ras_n,cas_n,we_n = 0,0,1,1), with `sd_ba` equal to the request bank and `sd_addr` equal to the request row.
- R4: In the cycle after ACTIVE, WRITE is driven (0,1,0,0) with the same bank. `sd_addr` carries the column in its low bits, bit 10 set and every other bit clear. `sd_dq` carries the request data with `sd_dq_oe`=1, and `sd_dqm` equals the inverted byte enables.
- R5: `dma_ack` is a one-cycle pulse in the first cycle after acceptance, which is exactly two cycles before the WRITE cycle. During that cycle the command pins show NOP.
- R6: The WRITE is followed by burst-minus-one dummy beats: 3 beats when `cfg_long`=0 and 7 when `cfg_long`=1. Each dummy beat drives NOP with `sd_dq_oe`=1 and all `sd_dqm` bits 1.
- R7: After the dummy beats come exactly `cfg_rwl` (0..7) write-recovery cycles. Each drives NOP with `sd_dq_oe`=0.
- R8: Next come `cfg_tpc`+1 precharge-wait cycles, each driving NOP. `busy` falls and `req_ready` rises in the cycle after the last of them. An access therefore keeps `busy` high for burst+`cfg_rwl`+`cfg_tpc`+3 cycles.
- R9: Changes to the request or configuration inputs after acceptance have no effect on the access in progress.
- R10: Whenever no command is due, including while idle, the pins show NOP with chip select low (0,1,1,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Row address |
| req_col | input | 9 | Column address |
| req_data | input | 16 | Write data word |
| req_be | input | 2 | Byte enables, 1 = write that byte |
| cfg_rwl | input | 3 | Write-recovery cycle count |
| cfg_tpc | input | 2 | Precharge-wait count minus one |
| cfg_long | input | 1 | Burst select, 0 = 4, 1 = 8 |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_ba | output | 2 | SDRAM bank address |
| sd_addr | output | 13 | SDRAM address, bit 10 = auto-precharge on WRITE |
| sd_dq | output | 16 | SDRAM write data |
| sd_dq_oe | output | 1 | Data bus output enable |
| sd_dqm | output | 2 | Data mask per byte, 1 = masked |
| dma_ack | output | 1 | DMA acknowledge pulse |
| busy | output | 1 | Access in progress |

## Verification
The bench covers every combination of burst select, recovery count and precharge count, and checks the pins on every cycle of each access. The zero recovery count is included in this sweep. A sequencer that decrements before testing would stall there for eight cycles, and one that loads the wrong count would end `busy` one cycle early or late. Alternate accesses keep `req_valid` high through the whole busy window. They also change the configuration and data while the access runs. These accesses catch a design that accepts a second request, lets `req_ready` rise too early, or reads live inputs instead of captured ones. Each check on the acknowledge cycle and the dummy beats would catch three faults: an acknowledge placed one cycle off, a dummy beat left unmasked, or a real beat masked with the byte enables uninverted.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_ACT,
    PH_WR,
    PH_DUMMY,
    PH_RWL,
    PH_TPC
  } phase_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_ACT   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_WRITE = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/sdram_wr_fsm.sv
module sdram_wr_fsm
  import sdram_wr_pkg::*;
#(
  parameter int BURST_SHORT = 4,
  parameter int BURST_LONG  = 8,
  parameter int RWL_W       = 3,
  parameter int TPC_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [RWL_W-1:0] cfg_rwl,
  input  logic [TPC_W-1:0] cfg_tpc,
  input  logic             cfg_long,
  output logic             req_ready,
  output logic             busy,
  output logic             accept,
  output phase_t           phase
);

  localparam int BW    = $clog2(BURST_LONG);
  localparam int MX1   = (RWL_W > TPC_W) ? RWL_W : TPC_W;
  localparam int CNT_W = (BW > MX1) ? BW : MX1;

  logic [CNT_W-1:0] cnt;
  logic [RWL_W-1:0] rwl_q;
  logic [TPC_W-1:0] tpc_q;
  logic             long_q;

  assign busy      = (phase != PH_IDLE);
  assign req_ready = ~busy;
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      rwl_q  <= '0;
      tpc_q  <= '0;
      long_q <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase  <= PH_LEAD;
            rwl_q  <= cfg_rwl;
            tpc_q  <= cfg_tpc;
            long_q <= cfg_long;
          end
        end
        PH_LEAD: phase <= PH_ACT;
        PH_ACT:  phase <= PH_WR;
        PH_WR: begin
          phase <= PH_DUMMY;
          cnt   <= long_q ? CNT_W'(BURST_LONG - 2) : CNT_W'(BURST_SHORT - 2);
        end
        PH_DUMMY: begin
          if (cnt == '0) begin
            if (rwl_q != '0) begin
              phase <= PH_RWL;
              cnt   <= CNT_W'(rwl_q) - CNT_W'(1);
            end else begin
              phase <= PH_TPC;
              cnt   <= CNT_W'(tpc_q);
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_RWL: begin
          if (cnt == '0) begin
            phase <= PH_TPC;
            cnt   <= CNT_W'(tpc_q);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_TPC: begin
          if (cnt == '0) phase <= PH_IDLE;
          else           cnt   <= cnt - CNT_W'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_TPC_END_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TPC && cnt == '0) |=> req_ready); // R8

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase != PH_TPC) |=> busy); // R2

endmodule

// File: rtl/sdram_wr_datapath.sv
module sdram_wr_datapath
  import sdram_wr_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int DATA_W = 16,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  phase_t            phase,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_data,
  input  logic [BE_W-1:0]   req_be,
  output logic [BANK_W-1:0] bank_q,
  output logic [ROW_W-1:0]  row_q,
  output logic [COL_W-1:0]  col_q,
  output logic [DATA_W-1:0] sd_dq,
  output logic              sd_dq_oe,
  output logic [BE_W-1:0]   sd_dqm
);

  logic [DATA_W-1:0] data_q;
  logic [BE_W-1:0]   be_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else if (accept) begin
      bank_q <= req_bank;
      row_q  <= req_row;
      col_q  <= req_col;
      data_q <= req_data;
      be_q   <= req_be;
    end
  end

  assign sd_dq    = data_q;
  assign sd_dq_oe = (phase == PH_WR) || (phase == PH_DUMMY);

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign sd_dqm[g] = (phase == PH_WR) ? ~be_q[g] : 1'b1;
  end

endmodule

// File: rtl/sdram_wr_cmd_enc.sv
module sdram_wr_cmd_enc
  import sdram_wr_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10
) (
  input  phase_t            phase,
  input  logic [BANK_W-1:0] bank_q,
  input  logic [ROW_W-1:0]  row_q,
  input  logic [COL_W-1:0]  col_q,
  output sd_cmd_t           cmd,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic              dma_ack
);

  logic [ROW_W-1:0] wr_addr;

  always_comb begin
    wr_addr               = '0;
    wr_addr[COL_W-1:0]    = col_q;
    wr_addr[AP_BIT]       = 1'b1;
  end

  always_comb begin
    cmd     = CMD_NOP;
    sd_ba   = '0;
    sd_addr = '0;
    case (phase)
      PH_ACT: begin
        cmd     = CMD_ACT;
        sd_ba   = bank_q;
        sd_addr = row_q;
      end
      PH_WR: begin
        cmd     = CMD_WRITE;
        sd_ba   = bank_q;
        sd_addr = wr_addr;
      end
      default: ;
    endcase
  end

  assign dma_ack = (phase == PH_LEAD);

endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
  import sdram_wr_pkg::*;
#(
  parameter int BANK_W      = 2,
  parameter int ROW_W       = 13,
  parameter int COL_W       = 9,
  parameter int DATA_W      = 16,
  parameter int AP_BIT      = 10,
  parameter int RWL_W       = 3,
  parameter int TPC_W       = 2,
  parameter int BURST_SHORT = 4,
  parameter int BURST_LONG  = 8,
  localparam int BE_W       = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_data,
  input  logic [BE_W-1:0]   req_be,
  input  logic [RWL_W-1:0]  cfg_rwl,
  input  logic [TPC_W-1:0]  cfg_tpc,
  input  logic              cfg_long,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [DATA_W-1:0] sd_dq,
  output logic              sd_dq_oe,
  output logic [BE_W-1:0]   sd_dqm,
  output logic              dma_ack,
  output logic              busy
);

  phase_t            phase;
  logic              accept;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  sd_cmd_t           cmd;

  sdram_wr_fsm #(
    .BURST_SHORT(BURST_SHORT), .BURST_LONG(BURST_LONG),
    .RWL_W(RWL_W), .TPC_W(TPC_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .cfg_rwl(cfg_rwl), .cfg_tpc(cfg_tpc), .cfg_long(cfg_long),
    .req_ready(req_ready), .busy(busy), .accept(accept), .phase(phase)
  );

  sdram_wr_datapath #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .phase(phase),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_data(req_data), .req_be(req_be),
    .bank_q(bank_q), .row_q(row_q), .col_q(col_q),
    .sd_dq(sd_dq), .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm)
  );

  sdram_wr_cmd_enc #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT)
  ) u_enc (
    .phase(phase), .bank_q(bank_q), .row_q(row_q), .col_q(col_q),
    .cmd(cmd), .sd_ba(sd_ba), .sd_addr(sd_addr), .dma_ack(dma_ack)
  );

  assign sd_cs_n  = cmd.cs_n;
  assign sd_ras_n = cmd.ras_n;
  assign sd_cas_n = cmd.cas_n;
  assign sd_we_n  = cmd.we_n;

  AST_ACK_LEADS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack |-> ##2 (cmd == CMD_WRITE && sd_dq_oe)); // R5

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack |=> !dma_ack); // R5

  AST_ACT_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |=> (cmd == CMD_WRITE && sd_addr[AP_BIT] && sd_ba == $past(sd_ba))); // R4

  AST_DUMMY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_dq_oe && cmd != CMD_WRITE) |-> (sd_dqm == '1)); // R6

  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RWL || phase == PH_TPC) |-> (cmd == CMD_NOP && !sd_dq_oe)); // R7

  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cmd == CMD_NOP && !dma_ack)); // R10

endmodule

// File: tb/test_sdram_wr_seq.sv
module test_sdram_wr_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [8:0]  req_col = '0;
  logic [15:0] req_data = '0;
  logic [1:0]  req_be = '0;
  logic [2:0]  cfg_rwl = '0;
  logic [1:0]  cfg_tpc = '0;
  logic        cfg_long = 1'b0;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [12:0] sd_addr;
  logic [15:0] sd_dq;
  logic        sd_dq_oe;
  logic [1:0]  sd_dqm;
  logic        dma_ack;
  logic        busy;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sdram_wr_seq i_sdram_wr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_data(req_data), .req_be(req_be),
    .cfg_rwl(cfg_rwl), .cfg_tpc(cfg_tpc), .cfg_long(cfg_long),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq(sd_dq), .sd_dq_oe(sd_dq_oe),
    .sd_dqm(sd_dqm), .dma_ack(dma_ack), .busy(busy)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // {cmd[3:0], ack, oe, dqm[1:0], busy, ready}
  function automatic logic [31:0] pins();
    return {22'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, dma_ack, sd_dq_oe, sd_dqm, busy, req_ready};
  endfunction

  function automatic logic [31:0] expv(logic [3:0] c, logic a, logic oe, logic [1:0] m, logic b);
    return {22'd0, c, a, oe, m, b, ~b};
  endfunction

  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, WRT = 4'b0100;

  task automatic run_one(int idx, int lng, int rwl, int tpc);
    int bl = lng ? 8 : 4;
    int t_end = bl + rwl + tpc + 3;
    logic hold = idx[0];
    logic [1:0]  bank = idx[1:0];
    logic [12:0] row = 13'((idx * 37 + 5) % 8192);
    logic [8:0]  col = 9'((idx * 5 + 3) % 512);
    logic [15:0] data = 16'hA5C3 ^ 16'(idx * 16'h1111);
    logic [1:0]  be = 2'(idx >> 1);
    @(negedge clk);
    req_bank = bank; req_row = row; req_col = col; req_data = data; req_be = be;
    cfg_long = lng[0]; cfg_rwl = 3'(rwl); cfg_tpc = 2'(tpc);
    req_valid = 1'b1;
    for (int k = 0; k <= t_end; k++) begin
      @(negedge clk);
      if (k == 0) begin
        // R9: disturb inputs after acceptance
        if (!hold) req_valid = 1'b0;
        cfg_long = ~cfg_long; cfg_rwl = ~cfg_rwl; cfg_tpc = ~cfg_tpc;
        req_data = ~req_data; req_bank = ~req_bank; req_row = ~req_row;
        req_col = ~req_col; req_be = ~req_be;
      end
      if (k == 0)
        chk("R5 ack lead cycle", pins(), expv(NOP, 1'b1, 1'b0, 2'b11, 1'b1));
      else if (k == 1) begin
        chk("R3 activate", pins(), expv(ACT, 1'b0, 1'b0, 2'b11, 1'b1));
        chk("R3 bank/row", {17'd0, sd_ba, sd_addr}, {17'd0, bank, row});
      end else if (k == 2) begin
        chk("R4 write", pins(), expv(WRT, 1'b0, 1'b1, ~be, 1'b1));
        chk("R4 bank/addr", {17'd0, sd_ba, sd_addr}, {17'd0, bank, 13'h400 | 13'(col)});
        chk("R9 data captured", {16'd0, sd_dq}, {16'd0, data});
      end else if (k <= bl + 1)
        chk("R6 dummy beat", pins(), expv(NOP, 1'b0, 1'b1, 2'b11, 1'b1));
      else if (k <= bl + 1 + rwl)
        chk("R7 recovery", pins(), expv(NOP, 1'b0, 1'b0, 2'b11, 1'b1));
      else if (k < t_end)
        chk("R8 precharge wait", pins(), expv(NOP, 1'b0, 1'b0, 2'b11, 1'b1));
      else begin
        req_valid = 1'b0;
        chk("R8 busy end / R10 idle nop", pins(), expv(NOP, 1'b0, 1'b0, 2'b11, 1'b0));
      end
    end
    @(negedge clk);
    chk("R2 no spurious accept", pins(), expv(NOP, 1'b0, 1'b0, 2'b11, 1'b0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int idx = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", pins(), expv(NOP, 1'b0, 1'b0, 2'b11, 1'b0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset release", pins(), expv(NOP, 1'b0, 1'b0, 2'b11, 1'b0));
    for (int lng = 0; lng < 2; lng++)
      for (int rwl = 0; rwl < 8; rwl++)
        for (int tpc = 0; tpc < 4; tpc++) begin
          run_one(idx, lng, rwl, tpc);
          idx++;
        end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule